// File: doc/BRIEF.md
# Programmable Watchdog Timer

This block is a watchdog timer controlled through one byte-wide register on a simple register port. The register holds a timeout as a count field and a power-of-four multiplier. Both are measured in ticks of an external 16 Hz strobe. The top bit of the register selects what a timeout does: it either requests a system reset or raises an interrupt. Software keeps the watchdog alive by touching the register, because a write or a read of it restarts the countdown.

The block also owns a watchdog flag. Software sees the flag as the top bit of a separate flags register, which is read-only. When the watchdog expires with reset steering selected, the block does three things: it pulses a reset request, it clears its own register to zero, and it pulses a request to clear the century bit in a neighbouring calendar register. When it expires with interrupt steering selected, it emits one interrupt pulse and then stays stopped until the next restart.

Top module: `wdog_timer`

## Requirements
- R1: The register layout is steer = bit 7, count = bits 6:2 and multiplier code = bits 1:0. After a restart, expiry occurs on tick number count × 4^code (1, 4, 16 or 64 per tick unit), counting only cycles where `tick16` is high. The expiry outputs change in the cycle after the clock edge that samples that tick.
- R2: While the register holds 0x00, the watchdog is disabled and never produces a reset request or an interrupt, however many ticks arrive.
- R3: A write with `busSel` = 0 (watchdog register) stores `wrData` and restarts the countdown from the new value.
- R4: A read with `busSel` = 0 returns the stored register value on `rdData` in the same cycle. It also restarts the countdown with that stored value.
- R5: Every restart, whether by read or by write, clears the watchdog flag.
- R6: On expiry the watchdog flag is set. It appears on `wdFlag` and as bit 7 of `rdData` when `busSel` = 1 (flags register), where bits 6:0 read 0.
- R7: On expiry with steer = 1, `resetReq` and `centuryClr` are high for exactly one cycle, `irqPulse` stays low, and the register reads 0x00 afterwards.
- R8: On expiry with steer = 0, `irqPulse` is high for exactly one cycle and `resetReq` stays low.
- R9: The flags register is read-only. A write with `busSel` = 1 changes neither the flag nor the register, and it does not restart the countdown. A read of it does not restart the countdown either.
- R10: A nonzero register whose count field is zero expires on the first tick after the restart.
- R11: After an interrupt expiry the timer stays stopped. No further pulse occurs and the flag stays set until the next restart.
- R12: After reset the register is 0x00, the flag is clear, the watchdog is stopped and all pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle strobe at 16 Hz, the countdown unit |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe |
| busSel | input | 1 | 0 = watchdog register, 1 = flags register |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the selected register |
| wdFlag | output | 1 | Watchdog flag |
| resetReq | output | 1 | One-cycle system reset request |
| irqPulse | output | 1 | One-cycle interrupt pulse |
| centuryClr | output | 1 | One-cycle request to clear the century bit |

## Verification
The assertions check several rules on every cycle:
- the two pulse outputs are never high together, and an interrupt pulse never lasts more than one cycle;
- a reset request coincides with a cleared register and a century-clear pulse;
- a restart always leaves the flag clear;
- a zero register never coexists with a running countdown;
- flags-register writes leave the watchdog state untouched.

Only the bench's scenarios can show the tick count until expiry for each multiplier code, and that a read restarts the countdown exactly as a write does. They also show that the timer stays idle after an interrupt expiry. The bench's cycle model confirms these against every output on every clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic {
    SEL_WDOG  = 1'b0,
    SEL_FLAGS = 1'b1
  } wdtSel_e;

  typedef struct packed {
    logic restart;
    logic useWrData;
    logic decrement;
    logic expire;
    logic steerReset;
  } wdtStrobes_t;

endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl #(
  parameter int REG_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     tick16,
  input  logic                     busWr,
  input  logic                     busRd,
  input  logic                     busSel,
  input  logic [REG_W-1:0]         wrData,
  input  logic [REG_W-1:0]         storedReg,
  input  logic                     cntLast,
  output wdt_pkg::wdtStrobes_t     strobes
);
  import wdt_pkg::*;

  logic selWdog;
  logic wrHit;
  logic rdHit;
  logic restart;
  logic [REG_W-1:0] nextVal;
  logic running;

  assign selWdog = (busSel == SEL_WDOG);
  assign wrHit   = busWr & selWdog;
  assign rdHit   = busRd & selWdog;
  assign restart = wrHit | rdHit;
  assign nextVal = wrHit ? wrData : storedReg;

  always_comb begin
    strobes            = '0;
    strobes.restart    = restart;
    strobes.useWrData  = wrHit;
    strobes.expire     = running & tick16 & cntLast & ~restart;
    strobes.decrement  = running & tick16 & ~cntLast & ~restart;
    strobes.steerReset = storedReg[REG_W-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
    end else if (restart) begin
      running <= (nextVal != '0);
    end else if (strobes.expire) begin
      running <= 1'b0;
    end
  end

  // R2: a cleared register never coexists with an active countdown
  p_zero_reg_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (storedReg == '0) |-> !running);

  // R11: an expiry leaves the timer stopped
  p_stop_after_expiry_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.expire) |=> !running);

endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath #(
  parameter int CNT_W  = 5,
  parameter int MULT_W = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  wdt_pkg::wdtStrobes_t          strobes,
  input  logic                          busSel,
  input  logic [CNT_W+MULT_W:0]         wrData,
  output logic [CNT_W+MULT_W:0]         storedReg,
  output logic                          cntLast,
  output logic [CNT_W+MULT_W:0]         rdData,
  output logic                          wdFlag,
  output logic                          resetReq,
  output logic                          irqPulse,
  output logic                          centuryClr
);
  import wdt_pkg::*;

  localparam int REG_W     = CNT_W + MULT_W + 1;
  localparam int MAX_SHIFT = 2 * ((1 << MULT_W) - 1);
  localparam int TMO_W     = CNT_W + MAX_SHIFT;

  logic [REG_W-1:0] wdReg;
  logic [REG_W-1:0] loadVal;
  logic [MULT_W:0]  shAmt;
  logic [TMO_W-1:0] timeout;
  logic [TMO_W-1:0] cnt;

  assign loadVal = strobes.useWrData ? wrData : wdReg;
  assign shAmt   = {loadVal[MULT_W-1:0], 1'b0};
  assign timeout = TMO_W'(loadVal[MULT_W +: CNT_W]) << shAmt;
  assign cntLast = (cnt <= TMO_W'(1));
  assign storedReg = wdReg;
  assign rdData  = (busSel == SEL_FLAGS) ? {wdFlag, {(REG_W-1){1'b0}}} : wdReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdReg <= '0;
    end else if (strobes.restart && strobes.useWrData) begin
      wdReg <= wrData;
    end else if (strobes.expire && strobes.steerReset) begin
      wdReg <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobes.restart) begin
      cnt <= timeout;
    end else if (strobes.decrement) begin
      cnt <= cnt - TMO_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdFlag     <= 1'b0;
      resetReq   <= 1'b0;
      irqPulse   <= 1'b0;
      centuryClr <= 1'b0;
    end else begin
      if (strobes.restart) begin
        wdFlag <= 1'b0;
      end else if (strobes.expire) begin
        wdFlag <= 1'b1;
      end
      resetReq   <= strobes.expire & strobes.steerReset;
      centuryClr <= strobes.expire & strobes.steerReset;
      irqPulse   <= strobes.expire & ~strobes.steerReset;
    end
  end

  // R7: a reset request comes with a cleared register and a century clear
  p_reset_clears_reg_r7: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> (wdReg == '0) && centuryClr);

  // R8: interrupt pulse lasts one cycle and never overlaps a reset request
  p_single_irq_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);
  p_pulse_exclusive_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({resetReq, irqPulse}));

  // R5: a restart always leaves the flag clear
  p_restart_clears_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.restart |=> !wdFlag);

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int CNT_W  = 5,
  parameter int MULT_W = 2,
  localparam int REG_W = CNT_W + MULT_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick16,
  input  logic             busWr,
  input  logic             busRd,
  input  logic             busSel,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             wdFlag,
  output logic             resetReq,
  output logic             irqPulse,
  output logic             centuryClr
);
  import wdt_pkg::*;

  wdtStrobes_t      strobes;
  logic [REG_W-1:0] storedReg;
  logic             cntLast;

  wdt_ctrl #(.REG_W(REG_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tick16    (tick16),
    .busWr     (busWr),
    .busRd     (busRd),
    .busSel    (busSel),
    .wrData    (wrData),
    .storedReg (storedReg),
    .cntLast   (cntLast),
    .strobes   (strobes)
  );

  wdt_datapath #(.CNT_W(CNT_W), .MULT_W(MULT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .busSel     (busSel),
    .wrData     (wrData),
    .storedReg  (storedReg),
    .cntLast    (cntLast),
    .rdData     (rdData),
    .wdFlag     (wdFlag),
    .resetReq   (resetReq),
    .irqPulse   (irqPulse),
    .centuryClr (centuryClr)
  );

  // R9: a write to the flags register leaves flag and register unchanged
  p_flags_write_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busSel == SEL_FLAGS && !strobes.expire)
      |=> $stable(wdFlag) && $stable(storedReg));

endmodule

// File: tb/wdog_timer_test.sv
`timescale 1ns/1ps
module wdog_timer_test;

  logic       clk = 1'b0;
  logic       rstN;
  logic       tick16;
  logic       busWr;
  logic       busRd;
  logic       busSel;
  logic [7:0] wrData;
  logic [7:0] rdData;
  logic       wdFlag;
  logic       resetReq;
  logic       irqPulse;
  logic       centuryClr;

  int checks = 0;
  int errors = 0;
  int irqSeen = 0;
  int rstSeen = 0;
  bit done = 0;

  // reference model state
  int mReg, mCnt, mRun, mFlag, mRst, mIrq, mCen;

  always #2 clk = ~clk;

  wdog_timer uut (
    .clk(clk), .rstN(rstN), .tick16(tick16), .busWr(busWr), .busRd(busRd),
    .busSel(busSel), .wrData(wrData), .rdData(rdData), .wdFlag(wdFlag),
    .resetReq(resetReq), .irqPulse(irqPulse), .centuryClr(centuryClr)
  );

  function automatic int tmoTicks(int v);
    return ((v >> 2) & 31) * (1 << (2 * (v & 3)));
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mReg = 0; mCnt = 0; mRun = 0; mFlag = 0; mRst = 0; mIrq = 0; mCen = 0;
    end else begin
      bit wrW, rdW;
      int nv;
      wrW = busWr && !busSel;
      rdW = busRd && !busSel;
      nv  = wrW ? int'(wrData) : mReg;
      mRst = 0; mIrq = 0; mCen = 0;
      if (wrW || rdW) begin
        mReg = nv; mCnt = tmoTicks(nv); mRun = (nv != 0); mFlag = 0;
      end else if (mRun != 0 && tick16) begin
        if (mCnt <= 1) begin
          mFlag = 1; mRun = 0;
          if ((mReg & 8'h80) != 0) begin
            mRst = 1; mCen = 1; mReg = 0;
          end else begin
            mIrq = 1;
          end
        end else begin
          mCnt = mCnt - 1;
        end
      end
    end
  end

  // every-cycle comparison against the model
  always begin
    @(negedge clk);
    #1;
    if (rstN === 1'b1 && !done) begin
      int expRd;
      expRd = busSel ? (mFlag << 7) : mReg;
      check(rdData == expRd[7:0], "R4 rdData vs model", rdData, expRd);
      check(wdFlag == mFlag[0], "R6 flag vs model", wdFlag, mFlag);
      check(resetReq == mRst[0], "R7 resetReq vs model", resetReq, mRst);
      check(centuryClr == mCen[0], "R7 centuryClr vs model", centuryClr, mCen);
      check(irqPulse == mIrq[0], "R8 irqPulse vs model", irqPulse, mIrq);
    end
  end

  always @(negedge clk) begin
    if (irqPulse) irqSeen++;
    if (resetReq) rstSeen++;
  end

  task automatic doWrite(bit sel, logic [7:0] d);
    @(negedge clk);
    busWr = 1'b1; busSel = sel; wrData = d;
    @(negedge clk);
    busWr = 1'b0; busSel = 1'b0;
  endtask

  task automatic doRead(bit sel, output int val);
    @(negedge clk);
    busRd = 1'b1; busSel = sel;
    #1 val = rdData;
    @(negedge clk);
    busRd = 1'b0; busSel = 1'b0;
  endtask

  task automatic tickN(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick16 = 1'b1;
      @(negedge clk);
      tick16 = 1'b0;
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired before the scenarios finished");
    done = 1;
    summary();
    $finish;
  end

  initial begin
    int rv;
    int snapI, snapR;
    rstN = 1'b0; tick16 = 1'b0; busWr = 1'b0; busRd = 1'b0; busSel = 1'b0; wrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R12 reset state
    check(rdData == 8'h00, "R12 register after reset", rdData, 0);
    check(!wdFlag && !resetReq && !irqPulse && !centuryClr, "R12 outputs after reset",
          {wdFlag, resetReq, irqPulse, centuryClr}, 0);

    // R1 / R8 / R6: 0x05 -> 4 ticks, interrupt steering
    doWrite(0, 8'h05);
    snapI = irqSeen;
    tickN(3);
    #1 check(irqSeen == snapI, "R1 no expiry before tick 4", irqSeen - snapI, 0);
    tickN(1);
    #1 check(irqPulse == 1'b1, "R1 expiry on tick 4", irqPulse, 1);
    check(wdFlag == 1'b1, "R6 flag set on expiry", wdFlag, 1);
    check(resetReq == 1'b0, "R8 no reset request", resetReq, 0);
    @(negedge clk);
    #1 check(irqPulse == 1'b0, "R8 interrupt pulse one cycle", irqPulse, 0);

    // R11 stays stopped
    snapI = irqSeen;
    tickN(10);
    #1 check(irqSeen == snapI, "R11 no pulse after expiry", irqSeen - snapI, 0);
    check(wdFlag == 1'b1, "R11 flag held", wdFlag, 1);

    // R4 / R5 read restarts
    doRead(0, rv);
    check(rv == 8'h05, "R4 read returns stored value", rv, 5);
    #1 check(wdFlag == 1'b0, "R5 restart clears flag", wdFlag, 0);
    tickN(2);
    doRead(0, rv);
    snapI = irqSeen;
    tickN(3);
    #1 check(irqSeen == snapI, "R4 read restarted countdown", irqSeen - snapI, 0);
    tickN(1);
    #1 check(irqPulse == 1'b1, "R4 expiry 4 ticks after read", irqPulse, 1);

    // R3 write restarts
    doWrite(0, 8'h05);
    tickN(3);
    doWrite(0, 8'h05);
    snapI = irqSeen;
    tickN(3);
    #1 check(irqSeen == snapI, "R3 write restarted countdown", irqSeen - snapI, 0);
    tickN(1);
    #1 check(irqPulse == 1'b1, "R3 expiry after rewrite", irqPulse, 1);

    // R9 flags register read-only, no restart
    doWrite(0, 8'h05);
    tickN(2);
    doWrite(1, 8'hFF);
    doRead(1, rv);
    tickN(2);
    #1 check(irqPulse == 1'b1, "R9 flags access did not restart", irqPulse, 1);
    doWrite(1, 8'h00);
    doRead(1, rv);
    check(rv == 8'h80, "R9 flag survives flags write", rv, 8'h80);
    doRead(0, rv);
    check(rv == 8'h05, "R9 register unchanged by flags write", rv, 5);

    // R7 reset steering
    doWrite(0, 8'h85);
    snapR = rstSeen;
    tickN(4);
    #1 check(resetReq == 1'b1 && centuryClr == 1'b1, "R7 reset and century pulses",
             {resetReq, centuryClr}, 3);
    check(irqPulse == 1'b0, "R7 no interrupt", irqPulse, 0);
    @(negedge clk);
    #1 check(rstSeen == snapR + 1, "R7 single reset pulse", rstSeen - snapR, 1);
    doRead(0, rv);
    check(rv == 8'h00, "R7 register cleared", rv, 0);

    // R2 disabled
    doWrite(0, 8'h00);
    snapI = irqSeen; snapR = rstSeen;
    tickN(100);
    #1 check(irqSeen == snapI && rstSeen == snapR, "R2 disabled never expires",
             irqSeen - snapI + rstSeen - snapR, 0);

    // R10 zero count, nonzero register
    doWrite(0, 8'h01);
    tickN(1);
    #1 check(irqPulse == 1'b1, "R10 expiry on first tick", irqPulse, 1);

    // R1 other multiplier codes
    doWrite(0, 8'h0A);
    snapI = irqSeen;
    tickN(31);
    #1 check(irqSeen == snapI, "R1 code 2 early", irqSeen - snapI, 0);
    tickN(1);
    #1 check(irqPulse == 1'b1, "R1 code 2 expiry at 32", irqPulse, 1);
    doWrite(0, 8'h07);
    snapI = irqSeen;
    tickN(63);
    #1 check(irqSeen == snapI, "R1 code 3 early", irqSeen - snapI, 0);
    tickN(1);
    #1 check(irqPulse == 1'b1, "R1 code 3 expiry at 64", irqPulse, 1);
    doWrite(0, 8'h7F);
    snapI = irqSeen;
    tickN(1983);
    #1 check(irqSeen == snapI, "R1 maximum timeout early", irqSeen - snapI, 0);
    tickN(1);
    #1 check(irqPulse == 1'b1, "R1 maximum timeout expiry", irqPulse, 1);

    repeat (2) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

endmodule